// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is a byte-wide configuration port with two addresses. Address 0 is the index port: it holds the number of the configuration register to reach. Address 1 is the data port: it reads or writes the register the index selects. Software reaches a register by writing its number to the index port and then reading or writing the data port. On a board the pair usually sits at base 0x2E/0x2F or 0x4E/0x4F. Turning the system address into the single address bit is left to the decoder in front of the block.

The port is closed after reset and ignores every access. It opens only when the opening key 0x87 is written to the index port in two consecutive writes. Writing the closing key 0xAA to the index port shuts it again. A three-state machine tracks the key:

- ST_LOCKED is the reset state.
- ST_KEY1 means one opening key has been seen.
- ST_OPEN means the port is open.

The transitions are:

- ST_LOCKED to ST_KEY1 on an index write of 0x87.
- ST_KEY1 to ST_OPEN on a second index write of 0x87.
- ST_KEY1 back to ST_LOCKED on any other index write or on any data write.
- ST_OPEN to ST_LOCKED on an index write of 0xAA.

Global registers include the logical-device selector, the device ID, the revision and the manufacturer ID. A window of registers from 0x30 upward is stored separately for each logical device. Bit 0 of register 0x30 is the enable of the logical device that owns that bank.

Top module: `cfgport_top`

## Requirements
- R1: After reset the port is in ST_LOCKED, `cfg_unlocked` is 0, `ld_select` is 0x00, all banked registers and `ld_enable` are 0. `bus_rdata` is 0xFF whenever `bus_rd` is low.
- R2: The port opens only after two index writes (`bus_addr`=0) of 0x87 in a row. If one 0x87 is followed by an index write of any other value, or by any data write, the key count starts over.
- R3: While the port is not open, reads of either port return 0xFF. Data writes have no effect on any register or on `ld_enable`.
- R4: While open, an index write of 0xAA closes the port and clears the index register to 0x00. Re-opening then reads the index back as 0x00.
- R5: While open, an index write of any value other than 0xAA stores it. An index read returns the stored value, and data accesses go to that register number.
- R6: Register 0x07 holds the logical-device selector. A data write to it sets `ld_select`, and a data read returns it.
- R7: Registers 0x20 and 0x21 read the device ID (0x20 is the high byte) and 0x22 reads the revision. Registers 0x23 and 0x24 read the manufacturer ID 0x1934, high byte (0x19) at 0x23. Writes to 0x20–0x24 are ignored.
- R8: Registers 0x30 to 0x30+BANK_REGS-1 (0x30–0x33 by default) are stored separately for each of NUM_LD logical devices. An access goes to the bank named by `ld_select`. A write to one bank is not visible in another.
- R9: `ld_enable[n]` equals bit 0 of register 0x30 in the bank of device n. It follows a write on the next clock.
- R10: If `ld_select` is NUM_LD or more, banked reads return 0x00 and banked writes are ignored. Register numbers that are not implemented read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state and the address |
| cfg_unlocked | output | 1 | High while the port is in ST_OPEN |
| ld_select | output | 8 | Current logical-device selector |
| ld_enable | output | NUM_LD | Enable of each logical device |

## Verification
A wrong key state shows at the ports at once. A port that opens early returns register contents instead of 0xFF and raises `cfg_unlocked` in the cycle after the faulty key write. A port that fails to open keeps returning 0xFF on the next index readback. A wrong bank write or a wrong select shows up on the next cycle as a changed `ld_enable` bit, or on the first readback of the affected bank. Because a reference model is compared against every output in every cycle, a divergence is caught in the cycle it first reaches a port.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_KEY1   = 2'd1,
        ST_OPEN   = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_OPEN   = 8'h87;
    localparam logic [7:0] KEY_CLOSE  = 8'hAA;
    localparam logic [7:0] REG_LDSEL  = 8'h07;
    localparam logic [7:0] REG_DEVHI  = 8'h20;
    localparam logic [7:0] REG_DEVLO  = 8'h21;
    localparam logic [7:0] REG_REV    = 8'h22;
    localparam logic [7:0] REG_VENHI  = 8'h23;
    localparam logic [7:0] REG_VENLO  = 8'h24;
    localparam logic [7:0] BANK_BASE  = 8'h30;
    localparam logic [7:0] IDLE_READ  = 8'hFF;
endpackage

// File: rtl/cfgport_keyfsm.sv
module cfgport_keyfsm
    import cfgport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output logic       port_open,
    output logic [7:0] idx_q
);
    key_state_e state_q, state_nx;

    // next-state logic of the key sequence
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_LOCKED: if (idx_wr && wdata == KEY_OPEN) state_nx = ST_KEY1;
            ST_KEY1: begin
                if (idx_wr)       state_nx = (wdata == KEY_OPEN) ? ST_OPEN : ST_LOCKED;
                else if (data_wr) state_nx = ST_LOCKED;
            end
            ST_OPEN:   if (idx_wr && wdata == KEY_CLOSE) state_nx = ST_LOCKED;
            default:   state_nx = ST_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_nx;
    end

    // outputs: open flag and index register
    always_comb port_open = (state_q == ST_OPEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (state_q == ST_OPEN && idx_wr) begin
            idx_q <= (wdata == KEY_CLOSE) ? 8'h00 : wdata;
        end
    end
endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank #(
    parameter int BANK_REGS = 4,
    parameter int OFS_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [OFS_W-1:0]            ofs,
    input  logic [7:0]                  wdata,
    output logic [BANK_REGS-1:0][7:0]   regs_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            for (int r = 0; r < BANK_REGS; r++) begin
                if (wr_en && ofs == OFS_W'(r)) regs_q[r] <= wdata;
            end
        end
    end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int          NUM_LD    = 8,
    parameter int          BANK_REGS = 4,
    parameter logic [15:0] DEV_ID    = 16'h0A17,
    parameter logic [7:0]  REV_ID    = 8'h03,
    parameter logic [15:0] VENDOR_ID = 16'h1934
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cfg_unlocked,
    output logic [7:0]        ld_select,
    output logic [NUM_LD-1:0] ld_enable
);
    localparam int OFS_W = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;

    logic       idx_wr, data_wr, port_open, sel_wr, in_bank;
    logic [7:0] idx_q, rd_val;
    logic [8:0] ofs_wide;
    logic [OFS_W-1:0] bank_ofs;
    logic [NUM_LD-1:0][BANK_REGS-1:0][7:0] bank_q;

    assign idx_wr  = bus_wr && !bus_addr;
    assign data_wr = bus_wr && bus_addr;

    cfgport_keyfsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .data_wr   (data_wr),
        .wdata     (bus_wdata),
        .port_open (port_open),
        .idx_q     (idx_q)
    );

    assign ofs_wide = {1'b0, idx_q} - {1'b0, BANK_BASE};
    assign in_bank  = !ofs_wide[8] && (ofs_wide < 9'(BANK_REGS));
    assign bank_ofs = ofs_wide[OFS_W-1:0];
    assign sel_wr   = port_open && data_wr && (idx_q == REG_LDSEL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ld_select <= 8'h00;
        else if (sel_wr) ld_select <= bus_wdata;
    end

    for (genvar g = 0; g < NUM_LD; g++) begin : g_ld
        logic bank_we;
        assign bank_we = port_open && data_wr && in_bank && (ld_select == 8'(g));
        cfgport_bank #(.BANK_REGS(BANK_REGS), .OFS_W(OFS_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bank_we),
            .ofs    (bank_ofs),
            .wdata  (bus_wdata),
            .regs_q (bank_q[g])
        );
        assign ld_enable[g] = bank_q[g][0][0];
    end

    always_comb begin
        rd_val = 8'h00;
        case (idx_q)
            REG_LDSEL: rd_val = ld_select;
            REG_DEVHI: rd_val = DEV_ID[15:8];
            REG_DEVLO: rd_val = DEV_ID[7:0];
            REG_REV:   rd_val = REV_ID;
            REG_VENHI: rd_val = VENDOR_ID[15:8];
            REG_VENLO: rd_val = VENDOR_ID[7:0];
            default: begin
                if (in_bank) begin
                    for (int g = 0; g < NUM_LD; g++) begin
                        if (ld_select == 8'(g)) rd_val = bank_q[g][bank_ofs];
                    end
                end
            end
        endcase
    end

    assign bus_rdata    = (!bus_rd || !port_open) ? IDLE_READ : (bus_addr ? rd_val : idx_q);
    assign cfg_unlocked = port_open;
endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
    parameter int NUM_LD = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              cfg_unlocked,
    input logic [7:0]        ld_select,
    input logic [NUM_LD-1:0] ld_enable
);
    a_r1_idle_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 8'hFF);

    a_r3_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |-> bus_rdata == 8'hFF);

    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_unlocked) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87));

    a_r4_close_key: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_unlocked);

    a_r3_locked_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |=> $stable(ld_enable));

    a_r6_select_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_unlocked && bus_wr && bus_addr) |=> $stable(ld_select));
endmodule

bind cfgport_top cfgport_checker #(.NUM_LD(NUM_LD)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .cfg_unlocked (cfg_unlocked),
    .ld_select    (ld_select),
    .ld_enable    (ld_enable)
);

// File: tb/tb_cfgport_top.sv
module tb_cfgport_top;
    localparam int NLD = 8;
    localparam int NBR = 4;
    localparam int DEVID = 16'h0A17;
    localparam int REVID = 8'h03;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, ld_select;
    logic cfg_unlocked;
    logic [NLD-1:0] ld_enable;

    int vectors = 0, fails = 0;
    bit done = 0;

    // reference model
    int mstate = 0;   // 0 locked, 1 one key seen, 2 open
    int midx = 0, msel = 0;
    int mbank[NLD][NBR];

    always #2 clk = ~clk;

    cfgport_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_unlocked(cfg_unlocked), .ld_select(ld_select), .ld_enable(ld_enable)
    );

    function automatic int mdata();
        if (midx == 8'h07) return msel;
        if (midx == 8'h20) return DEVID >> 8;
        if (midx == 8'h21) return DEVID & 8'hFF;
        if (midx == 8'h22) return REVID;
        if (midx == 8'h23) return 8'h19;
        if (midx == 8'h24) return 8'h34;
        if (midx >= 8'h30 && midx < 8'h30 + NBR && msel < NLD) return mbank[msel][midx - 8'h30];
        return 0;
    endfunction

    task automatic cyc(input bit a, input bit rd, input bit wr, input int d, input string tag);
        int exp_rd;
        logic [NLD-1:0] exp_en;
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = 8'(d);
        #1;
        exp_rd = 8'hFF;
        if (rd && mstate == 2) exp_rd = a ? mdata() : midx;
        for (int i = 0; i < NLD; i++) exp_en[i] = mbank[i][0][0];
        vectors++;
        if (bus_rdata !== 8'(exp_rd) || cfg_unlocked !== (mstate == 2) ||
            ld_select !== 8'(msel) || ld_enable !== exp_en) begin
            fails++;
            $display("FAIL %s: rdata=%h exp %h, unlocked=%b exp %b, sel=%h exp %h, en=%b exp %b",
                     tag, bus_rdata, 8'(exp_rd), cfg_unlocked, (mstate == 2),
                     ld_select, 8'(msel), ld_enable, exp_en);
        end
        @(posedge clk);
        if (wr && !a) begin
            if (mstate == 0) begin
                if (d == 8'h87) mstate = 1;
            end else if (mstate == 1) begin
                mstate = (d == 8'h87) ? 2 : 0;
            end else if (d == 8'hAA) begin
                mstate = 0; midx = 0;
            end else begin
                midx = d;
            end
        end else if (wr && a) begin
            if (mstate == 1) mstate = 0;
            else if (mstate == 2) begin
                if (midx == 8'h07) msel = d;
                else if (midx >= 8'h30 && midx < 8'h30 + NBR && msel < NLD)
                    mbank[msel][midx - 8'h30] = d;
            end
        end
    endtask

    task automatic iw(input int d, input string t); cyc(0, 0, 1, d, t); endtask
    task automatic dw(input int d, input string t); cyc(1, 0, 1, d, t); endtask
    task automatic dr(input string t);              cyc(1, 1, 0, 0, t); endtask
    task automatic ir(input string t);              cyc(0, 1, 0, 0, t); endtask
    task automatic reg_wr(input int r, input int d, input string t); iw(r, t); dw(d, t); endtask
    task automatic reg_rd(input int r, input string t);              iw(r, t); dr(t); endtask

    initial begin
        for (int i = 0; i < NLD; i++) for (int j = 0; j < NBR; j++) mbank[i][j] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, idle read value
        cyc(0, 0, 0, 0, "R1 idle");
        ir("R1 index read after reset");
        dr("R1 data read after reset");
        // R3: locked accesses
        dw(8'h01, "R3 locked data write");
        dr("R3 locked data read");
        // R2: broken key sequences
        iw(8'h87, "R2 first key");
        iw(8'h12, "R2 other value breaks key");
        iw(8'h87, "R2 first key again");
        ir("R2 read does not break key");
        dw(8'h01, "R3 data write in half key");
        iw(8'h87, "R2 single key after data write");
        ir("R2 still locked");
        iw(8'h87, "R2 second key opens");
        ir("R5 index after open");
        // R5 / R6
        iw(8'h31, "R5 set index");
        ir("R5 index readback");
        reg_wr(8'h07, 8'h02, "R6 select device 2");
        reg_rd(8'h07, "R6 select readback");
        // R8 / R9
        reg_wr(8'h30, 8'h01, "R9 enable device 2");
        reg_wr(8'h31, 8'hA5, "R8 bank 2 write");
        reg_wr(8'h33, 8'h3C, "R8 bank 2 top register");
        reg_wr(8'h07, 8'h03, "R6 select device 3");
        reg_rd(8'h31, "R8 bank 3 is separate");
        reg_wr(8'h31, 8'h5A, "R8 bank 3 write");
        reg_wr(8'h30, 8'hFF, "R9 enable device 3");
        reg_wr(8'h30, 8'hFE, "R9 disable device 3");
        reg_wr(8'h07, 8'h02, "R6 back to device 2");
        reg_rd(8'h31, "R8 bank 2 kept value");
        reg_rd(8'h33, "R8 bank 2 top register");
        reg_wr(8'h07, 8'h07, "R6 last device");
        reg_wr(8'h30, 8'h01, "R9 enable last device");
        // R7: identification registers
        reg_rd(8'h20, "R7 device id high");
        reg_rd(8'h21, "R7 device id low");
        reg_rd(8'h22, "R7 revision");
        reg_rd(8'h23, "R7 vendor high");
        reg_rd(8'h24, "R7 vendor low");
        reg_wr(8'h23, 8'h00, "R7 write ignored");
        reg_rd(8'h23, "R7 vendor unchanged");
        reg_wr(8'h20, 8'h55, "R7 write ignored");
        reg_rd(8'h20, "R7 device id unchanged");
        // R10: out-of-range selector and holes
        reg_wr(8'h07, 8'h09, "R10 select missing device");
        reg_wr(8'h30, 8'h00, "R10 write ignored");
        reg_rd(8'h30, "R10 read zero");
        reg_wr(8'h07, 8'h02, "R10 valid select");
        reg_wr(8'h34, 8'h77, "R10 beyond window");
        reg_rd(8'h34, "R10 beyond window reads zero");
        reg_rd(8'h10, "R10 hole reads zero");
        reg_rd(8'h30, "R10 bank 2 untouched");
        // R4: closing key
        iw(8'h31, "R4 index before close");
        iw(8'hAA, "R4 close key");
        ir("R4 locked index read");
        dr("R3 locked data read");
        dw(8'h00, "R3 locked write ignored");
        iw(8'h87, "R2 reopen");
        iw(8'h87, "R2 reopen");
        ir("R4 index cleared by close");
        reg_rd(8'h30, "R3 enable kept while locked");
        iw(8'h87, "R5 key value as register number");
        ir("R5 index holds 0x87");
        iw(8'hAA, "R4 close again");
        cyc(0, 0, 0, 0, "R1 idle");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: run did not end, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule